// File: doc/BRIEF.md
# Dual Oscillator Aging Measurement Controller

This block compares two free-running oscillator signals to estimate how long a chip has been in use. One oscillator is kept unstressed and powered only while it is measured. The other ages during normal operation, so it slows down over time. The block counts the reference oscillator first and the stressed oscillator second. Both counts use one shared counter. A multiplexer in front of that counter picks which oscillator's edges are counted. The length of each counting window is a fixed number of system clock cycles. The window therefore stays the same no matter how far either oscillator has drifted.

A host pulses `start_i` and then waits for the one-cycle `done_o` pulse. At that point the block presents both counts. It also presents their signed difference, reference minus stressed. A larger positive difference means the stressed path has been used longer, which raises the chance that the part is recycled. The difference is compared against a threshold supplied by the host, and a flag is raised when the difference reaches or passes that threshold. Each oscillator passes through its own two-flop synchronizer and rising-edge detector before it is counted. Each oscillator must toggle at less than half the system clock rate.

Top module: `ro_age_meter`

## Requirements
- R1: After reset, `ref_cnt_o`, `str_cnt_o`, `diff_o`, `aged_o`, `done_o`, `busy_o` and `ref_en_o` are all zero.
- R2: A `start_i` sampled high while idle starts a measurement. The reference window covers the next WIN_CYC clock edges and the stressed window covers the WIN_CYC edges after it. `done_o` is high for exactly one cycle, starting at the 2*WIN_CYC-th edge after the edge that sampled `start_i`.
- R3: `ref_cnt_o` equals the number of synchronized rising edges of `ref_osc_i` detected during the reference window.
- R4: `str_cnt_o` equals the number of synchronized rising edges of `str_osc_i` detected during the stressed window.
- R5: When `done_o` is high, `diff_o` is the two's complement value `ref_cnt_o - str_cnt_o`, one bit wider than a count.
- R6: When `done_o` is high, `aged_o` is 1 exactly when signed `diff_o` is greater than or equal to signed `threshold_i` as sampled at the edge that ends the stressed window.
- R7: A `start_i` pulse that arrives while a measurement is running is ignored. It changes neither the timing of `done_o` nor the reported results.
- R8: Between `done_o` and the next start, all results hold their values.
- R9: `ref_en_o` (enable for the reference oscillator) is high during the reference window only.
- R10: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Measurement request |
| ref_osc_i | input | 1 | Reference oscillator signal |
| str_osc_i | input | 1 | Stressed oscillator signal |
| threshold_i | input | CNT_W+1 | Signed threshold for the aged flag |
| ref_en_o | output | 1 | Power enable for the reference oscillator |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ref_cnt_o | output | CNT_W | Reference edge count |
| str_cnt_o | output | CNT_W | Stressed edge count |
| diff_o | output | CNT_W+1 | Signed difference, reference minus stressed |
| aged_o | output | 1 | Difference has reached the threshold |

## Verification
The oscillators are modelled with periods that are whole multiples of the system clock, and the window length is a multiple of every period used. The exact count is then known arithmetically. An off-by-one window, or an edge lost at the point where the windows hand over, shows up as a count that is one too large or one too small. The period pairs are swept in both directions, so the difference is positive in some runs and negative in others. A design that compared unsigned values, or subtracted in the wrong order, would therefore raise the wrong flag. The threshold is set one below, equal to and one above the true difference, which catches a strict comparison used where an inclusive one is required. The bench also issues a second start in the middle of a run and reads the results again after completion. A design that restarted on that pulse, or let the results drift while idle, would move `done_o` or change its outputs.

// File: rtl/ro_age_pkg.sv
package ro_age_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REF  = 2'd1,
    ST_STR  = 2'd2
  } meas_st_e;

  localparam int unsigned NUM_OSC = 2;
  localparam int unsigned OSC_REF = 0;
  localparam int unsigned OSC_STR = 1;
endpackage

// File: rtl/ro_edge_sync.sv
module ro_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], osc_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ro_win_timer.sv
module ro_win_timer #(
  parameter int unsigned WIN_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned TW = $clog2(WIN_CYC + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(WIN_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/ro_edge_counter.sv
module ro_edge_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign next_o = cnt_q + CNT_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= next_o;
  end
endmodule

// File: rtl/ro_age_meter.sv
module ro_age_meter
  import ro_age_pkg::*;
#(
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned WIN_CYC  = 4096,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    ref_osc_i,
  input  logic                    str_osc_i,
  input  logic signed [CNT_W:0]   threshold_i,
  output logic                    ref_en_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        ref_cnt_o,
  output logic [CNT_W-1:0]        str_cnt_o,
  output logic signed [CNT_W:0]   diff_o,
  output logic                    aged_o
);
  localparam int unsigned DIFF_W = CNT_W + 1;

  meas_st_e             state_q;
  logic [NUM_OSC-1:0]   osc_vec;
  logic [NUM_OSC-1:0]   rise;
  logic                 sel_rise;
  logic                 counting;
  logic                 start_ok;
  logic                 win_last;
  logic                 win_load;
  logic [CNT_W-1:0]     cnt_next;
  logic signed [DIFF_W-1:0] diff_next;

  logic [CNT_W-1:0]         ref_q, str_q;
  logic signed [DIFF_W-1:0] diff_q;
  logic                     aged_q, done_q;

  assign osc_vec[OSC_REF] = ref_osc_i;
  assign osc_vec[OSC_STR] = str_osc_i;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
    ro_edge_sync #(.STAGES(SYNC_STG)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .osc_i (osc_vec[g]),
      .rise_o(rise[g])
    );
  end

  // shared counter input multiplexer
  assign sel_rise = (state_q == ST_REF) ? rise[OSC_REF] : rise[OSC_STR];
  assign counting = (state_q != ST_IDLE);
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign win_load = start_ok || ((state_q == ST_REF) && win_last);

  ro_win_timer #(.WIN_CYC(WIN_CYC)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(win_load),
    .run_i (counting),
    .last_o(win_last)
  );

  ro_edge_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (win_load),
    .inc_i (counting && sel_rise),
    .next_o(cnt_next)
  );

  assign diff_next = $signed({1'b0, ref_q}) - $signed({1'b0, cnt_next});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ref_q   <= '0;
      str_q   <= '0;
      diff_q  <= '0;
      aged_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_REF;
        ST_REF: if (win_last) begin
          ref_q   <= cnt_next;
          state_q <= ST_STR;
        end
        ST_STR: if (win_last) begin
          str_q   <= cnt_next;
          diff_q  <= diff_next;
          aged_q  <= (diff_next >= threshold_i);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ref_en_o  = (state_q == ST_REF);
  assign busy_o    = counting;
  assign done_o    = done_q;
  assign ref_cnt_o = ref_q;
  assign str_cnt_o = str_q;
  assign diff_o    = diff_q;
  assign aged_o    = aged_q;
endmodule

// File: rtl/ro_age_meter_chk.sv
module ro_age_meter_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic signed [CNT_W:0] threshold_i,
  input logic                  ref_en_o,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [CNT_W-1:0]      ref_cnt_o,
  input logic [CNT_W-1:0]      str_cnt_o,
  input logic signed [CNT_W:0] diff_o,
  input logic                  aged_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o) && !busy_o); // R10

  AST_DIFF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> diff_o == ($signed({1'b0, ref_cnt_o}) - $signed({1'b0, str_cnt_o}))); // R5

  AST_AGED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> aged_o == (diff_o >= $past(threshold_i))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(str_cnt_o) && $stable(diff_o) && $stable(aged_o)); // R8

  AST_REF_EN_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> busy_o); // R9

  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ref_en_o && start_i) |=> !ref_en_o); // R7
endmodule

bind ro_age_meter ro_age_meter_chk #(.CNT_W(CNT_W)) i_ro_age_meter_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .threshold_i(threshold_i),
  .ref_en_o   (ref_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ref_cnt_o  (ref_cnt_o),
  .str_cnt_o  (str_cnt_o),
  .diff_o     (diff_o),
  .aged_o     (aged_o)
);

// File: tb/test_ro_age_meter.sv
`timescale 1ns/1ps
module test_ro_age_meter;
  localparam int unsigned CNT_W = 20;
  localparam int unsigned W     = 60;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic ref_osc_i = 1'b0;
  logic str_osc_i = 1'b0;
  logic signed [CNT_W:0] threshold_i = '0;
  logic ref_en_o, busy_o, done_o, aged_o;
  logic [CNT_W-1:0] ref_cnt_o, str_cnt_o;
  logic signed [CNT_W:0] diff_o;

  int checks = 0;
  int fails  = 0;
  int kr = 4;
  int ks = 5;

  ro_age_meter #(.CNT_W(CNT_W), .WIN_CYC(W)) i_ro_age_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .ref_osc_i(ref_osc_i), .str_osc_i(str_osc_i), .threshold_i(threshold_i),
    .ref_en_o(ref_en_o), .busy_o(busy_o), .done_o(done_o),
    .ref_cnt_o(ref_cnt_o), .str_cnt_o(str_cnt_o), .diff_o(diff_o), .aged_o(aged_o)
  );

  always #5 clk_i = ~clk_i;

  // oscillator periods are kr/ks system clocks; toggles kept off clock edges
  initial begin
    #2;
    forever begin
      #(kr * 5) ref_osc_i = ~ref_osc_i;
    end
  end
  initial begin
    #2;
    forever begin
      #(ks * 5) str_osc_i = ~str_osc_i;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic measure(input int pr, input int ps, input int toff, input bit mid_start);
    int n;
    int exp_ref, exp_str, exp_diff;
    bit en_ok, busy_ok;
    logic [CNT_W-1:0] h_ref, h_str;
    logic signed [CNT_W:0] h_diff;
    logic h_aged;
    kr = pr;
    ks = ps;
    repeat (40) @(negedge clk_i);
    exp_ref  = W / pr;
    exp_str  = W / ps;
    exp_diff = exp_ref - exp_str;
    threshold_i = (CNT_W+1)'(exp_diff + toff);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    en_ok = 1'b1;
    busy_ok = 1'b1;
    while (!done_o && n < 4 * W) begin
      if (ref_en_o != (n <= W)) en_ok = 1'b0;
      if (busy_o != (n <= 2 * W)) busy_ok = 1'b0;
      if (mid_start && n == W + 3) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk_i);
      n++;
    end
    start_i = 1'b0;
    chk(n == 2 * W + 1, "R2 done timing", n, 2 * W + 1);
    chk(en_ok, "R9 ref enable window", en_ok, 1);
    chk(busy_ok && !busy_o, "R10 busy window", busy_o, 0);
    chk(ref_cnt_o == CNT_W'(exp_ref), "R3 reference count", ref_cnt_o, exp_ref);
    chk(str_cnt_o == CNT_W'(exp_str), "R4 stressed count", str_cnt_o, exp_str);
    chk(diff_o == (CNT_W+1)'(exp_diff), "R5 difference", diff_o, exp_diff);
    chk(aged_o == (toff <= 0), "R6 aged flag", aged_o, (toff <= 0));
    if (mid_start) chk(n == 2 * W + 1, "R7 start ignored while busy", n, 2 * W + 1);
    h_ref = ref_cnt_o; h_str = str_cnt_o; h_diff = diff_o; h_aged = aged_o;
    @(negedge clk_i);
    chk(!done_o, "R2 done single cycle", done_o, 0);
    threshold_i = -threshold_i;
    repeat (6) @(negedge clk_i);
    chk(ref_cnt_o == h_ref && str_cnt_o == h_str && diff_o == h_diff && aged_o == h_aged,
        "R8 results held", diff_o, h_diff);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int rp [4] = '{3, 4, 5, 6};
    int sp [6] = '{3, 4, 5, 6, 10, 12};
    int idx = 0;
    repeat (3) @(negedge clk_i);
    chk(ref_cnt_o == 0 && str_cnt_o == 0 && diff_o == 0, "R1 reset counts", diff_o, 0);
    chk(!aged_o && !done_o && !busy_o && !ref_en_o, "R1 reset flags", busy_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 6; j++) begin
        measure(rp[i], sp[j], (idx % 3) - 1, (idx % 4) == 1);
        idx++;
      end
    end
    finish_run();
  end
endmodule